// File: doc/BRIEF.md
# Interruptible Block-Move Engine

This block copies a run of bytes from one place in memory to another. The count and both pointers live in registers that look like a processor's accumulator and two index registers. A source bank and a destination bank give the upper address bits. After a start pulse the engine works through the block one byte at a time. Every byte takes a fixed slot of seven clock cycles: one read, one write, and five internal cycles. The ascending form moves the pointers upward and the descending form moves them downward.

The count and pointer registers hold all of the engine's progress. Because of this, an interrupt request can stop the move at any byte boundary. The surrounding logic can then service the interrupt and later restart the engine with the values it reads back from those registers. The move carries on from where it stopped. If the destination is placed one byte above the source and the ascending form is used, the first byte is copied into every following byte, so the move also works as a memory fill.

Top module: `bmv_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `mem_req` are low, and `acc_out`, `x_out`, `y_out` and `dbank_out` are zero.
- R2: Each byte occupies seven consecutive busy cycles. In the first cycle of the slot there is a read request (`mem_req`=1, `mem_we`=0) at address {source bank, X}. In the third cycle there is a write request (`mem_req`=1, `mem_we`=1) at {destination bank, Y}, carrying the byte just read. The other five cycles make no request. Read data is returned on `mem_rdata` one cycle after the read request.
- R3: With `dir_desc`=0 (ascending), X and Y each increase by one after every byte. They wrap from FFFF to 0000 without changing either bank.
- R4: With `dir_desc`=1 (descending), X and Y each decrease by one after every byte. They wrap from 0000 to FFFF without changing either bank.
- R5: The accumulator holds the byte count minus one, so a single start can move up to 65536 bytes. A move that is not interrupted transfers acc+1 bytes. `busy` is high for exactly 7*(acc+1) cycles, starting in the cycle after the start pulse is sampled. `acc_out` then ends at FFFF.
- R6: `done` is high for exactly one cycle: the first cycle with `busy` low after the final byte. `done` stays low when the engine stops because of an interrupt.
- R7: If `irq` is high in the last cycle of a byte that is not the final byte, the engine stops after that byte. `busy` falls, and `acc_out`, `x_out` and `y_out` show the progress made so far. Restarting with those values finishes the move with the same memory contents as a move that was never interrupted. On the final byte, completion takes priority over `irq`.
- R8: `dbank_out` takes the value of `dst_bank` when a start is accepted and keeps it until the next accepted start.
- R9: A start pulse while `busy` is high is ignored. The values on the load inputs at that time have no effect.
- R10: With the source and destination in the same bank, Y = X+1 and the ascending form, every destination byte ends equal to the original byte at the first source address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move (sampled only while idle) |
| dir_desc | input | 1 | 0 ascending, 1 descending |
| irq | input | 1 | Interrupt request, sampled in the last cycle of each byte |
| acc_in | input | 16 | Byte count minus one to load |
| x_in | input | 16 | Source pointer to load |
| y_in | input | 16 | Destination pointer to load |
| src_bank | input | 8 | Source bank |
| dst_bank | input | 8 | Destination bank |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 16 | Current accumulator (remaining count minus one) |
| x_out | output | 16 | Current source pointer |
| y_out | output | 16 | Current destination pointer |
| dbank_out | output | 8 | Data bank register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 24 | Bank and pointer address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |

## Verification
The hardest case to reach from the ports is an interrupt that lands on the last cycle of a chosen byte. The stop, the values read back and the resumed run must together give the same memory image as a move that was never interrupted. The stimulus counts busy cycles from the start pulse and raises `irq` inside a randomly chosen byte slot. It then restarts the engine with the values read from `acc_out`, `x_out` and `y_out`, and compares memory with a reference copy that is updated byte by byte, so overlapping moves are also handled. Directed cases cover wrap at both ends of a bank, an interrupt on the final byte, the overlapping fill, and a start pulse carrying junk values in the middle of a move.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

    typedef enum logic {
        MV_ASC  = 1'b0,
        MV_DESC = 1'b1
    } mv_dir_e;

    // One-hot-ish decode of where the engine is inside a byte slot
    typedef struct packed {
        logic rd;    // issue the read
        logic cap;   // capture returned read data
        logic wr;    // issue the write
        logic last;  // final cycle of the slot
    } ph_dec_t;

    function automatic ph_dec_t ph_decode(input int unsigned ph,
                                          input int unsigned rd_ph,
                                          input int unsigned wr_ph,
                                          input int unsigned last_ph);
        ph_dec_t d;
        d.rd   = (ph == rd_ph);
        d.cap  = (ph == rd_ph + 1);
        d.wr   = (ph == wr_ph);
        d.last = (ph == last_ph);
        return d;
    endfunction

endpackage

// File: rtl/bmv_seq.sv
module bmv_seq
    import bmv_pkg::*;
#(
    parameter int unsigned BYTE_CYCLES = 7,
    parameter int unsigned RD_PH       = 0,
    parameter int unsigned WR_PH       = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    irq_i,
    input  logic    acc_zero_i,
    output logic    load_o,
    output logic    step_o,
    output logic    busy_o,
    output logic    done_o,
    output ph_dec_t dec_o
);

    localparam int unsigned PH_W    = $clog2(BYTE_CYCLES);
    localparam int unsigned LAST_PH = BYTE_CYCLES - 1;

    logic [PH_W-1:0] ph_q;
    logic            busy_q;
    logic            done_q;

    always_comb begin
        if (busy_q) dec_o = ph_decode(32'(ph_q), RD_PH, WR_PH, LAST_PH);
        else        dec_o = '0;
    end

    assign load_o = start_i && !busy_q;
    assign step_o = busy_q && dec_o.last;
    assign busy_o = busy_q;
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ph_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                ph_q   <= '0;
            end else if (busy_q) begin
                if (dec_o.last) begin
                    ph_q <= '0;
                    if (acc_zero_i) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else if (irq_i) begin
                        busy_q <= 1'b0;
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    // R6: completion pulse lasts one cycle and only while idle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    // R7: interrupt at a non-final byte boundary halts without completion
    a_r7_irq_halt: assert property (@(posedge clk) disable iff (rst)
        (step_o && irq_i && !acc_zero_i) |=> (!busy_o && !done_o));
    // R9: a start pulse mid-slot does not disturb the running move
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !dec_o.last) |=> busy_o);

endmodule

// File: rtl/bmv_regs.sv
module bmv_regs
    import bmv_pkg::*;
#(
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_i,
    input  mv_dir_e           dir_i,
    input  logic [PTR_W-1:0]  acc_i,
    input  logic [PTR_W-1:0]  x_i,
    input  logic [PTR_W-1:0]  y_i,
    input  logic [BANK_W-1:0] sbank_i,
    input  logic [BANK_W-1:0] dbank_i,
    output logic [PTR_W-1:0]  acc_q,
    output logic [PTR_W-1:0]  x_q,
    output logic [PTR_W-1:0]  y_q,
    output logic [BANK_W-1:0] sbank_q,
    output logic [BANK_W-1:0] dbank_q,
    output mv_dir_e           dir_q,
    output logic              acc_zero_o
);

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                  input mv_dir_e d);
        return (d == MV_DESC) ? p - PTR_W'(1) : p + PTR_W'(1);
    endfunction

    assign acc_zero_o = (acc_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            x_q     <= '0;
            y_q     <= '0;
            sbank_q <= '0;
            dbank_q <= '0;
            dir_q   <= MV_ASC;
        end else if (load_i) begin
            acc_q   <= acc_i;
            x_q     <= x_i;
            y_q     <= y_i;
            sbank_q <= sbank_i;
            dbank_q <= dbank_i;
            dir_q   <= dir_i;
        end else if (step_i) begin
            acc_q <= acc_q - PTR_W'(1);
            x_q   <= ptr_next(x_q, dir_q);
            y_q   <= ptr_next(y_q, dir_q);
        end
    end

    // R3: ascending pointers advance by one per byte, wrapping in the bank
    a_r3_asc_step: assert property (@(posedge clk) disable iff (rst)
        (step_i && dir_q == MV_ASC) |=>
            (x_q == $past(x_q) + PTR_W'(1)) && (y_q == $past(y_q) + PTR_W'(1)));
    // R4: descending pointers retreat by one per byte
    a_r4_desc_step: assert property (@(posedge clk) disable iff (rst)
        (step_i && dir_q == MV_DESC) |=>
            (x_q == $past(x_q) - PTR_W'(1)) && (y_q == $past(y_q) - PTR_W'(1)));
    // R5: count falls by one per byte
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (acc_q == $past(acc_q) - PTR_W'(1)));
    // R8: data bank changes only on an accepted start
    a_r8_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(dbank_q));

endmodule

// File: rtl/bmv_mport.sv
module bmv_mport
    import bmv_pkg::*;
#(
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned BANK_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ph_dec_t                 dec_i,
    input  logic [BANK_W-1:0]       sbank_i,
    input  logic [BANK_W-1:0]       dbank_i,
    input  logic [PTR_W-1:0]        x_i,
    input  logic [PTR_W-1:0]        y_i,
    input  logic [DATA_W-1:0]       rdata_i,
    output logic                    req_o,
    output logic                    we_o,
    output logic [PTR_W+BANK_W-1:0] addr_o,
    output logic [DATA_W-1:0]       wdata_o
);

    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst)            data_q <= '0;
        else if (dec_i.cap) data_q <= rdata_i;
    end

    always_comb begin
        req_o   = dec_i.rd || dec_i.wr;
        we_o    = dec_i.wr;
        addr_o  = '0;
        wdata_o = '0;
        if (dec_i.rd) begin
            addr_o = {sbank_i, x_i};
        end else if (dec_i.wr) begin
            addr_o  = {dbank_i, y_i};
            wdata_o = data_q;
        end
    end

    // R2: write data is the value captured from the preceding read
    a_r2_wdata_captured: assert property (@(posedge clk) disable iff (rst)
        dec_i.cap |=> (data_q == $past(rdata_i)));

endmodule

// File: rtl/bmv_engine.sv
module bmv_engine
    import bmv_pkg::*;
#(
    parameter int unsigned PTR_W       = 16,
    parameter int unsigned BANK_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned BYTE_CYCLES = 7,
    parameter int unsigned RD_PH       = 0,
    parameter int unsigned WR_PH       = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    dir_desc,
    input  logic                    irq,
    input  logic [PTR_W-1:0]        acc_in,
    input  logic [PTR_W-1:0]        x_in,
    input  logic [PTR_W-1:0]        y_in,
    input  logic [BANK_W-1:0]       src_bank,
    input  logic [BANK_W-1:0]       dst_bank,
    output logic                    busy,
    output logic                    done,
    output logic [PTR_W-1:0]        acc_out,
    output logic [PTR_W-1:0]        x_out,
    output logic [PTR_W-1:0]        y_out,
    output logic [BANK_W-1:0]       dbank_out,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [PTR_W+BANK_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata
);

    ph_dec_t           dec;
    logic              load;
    logic              step;
    logic              acc_zero;
    logic [BANK_W-1:0] sbank_q;
    mv_dir_e           dir_q;

    bmv_seq #(
        .BYTE_CYCLES (BYTE_CYCLES),
        .RD_PH       (RD_PH),
        .WR_PH       (WR_PH)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .irq_i      (irq),
        .acc_zero_i (acc_zero),
        .load_o     (load),
        .step_o     (step),
        .busy_o     (busy),
        .done_o     (done),
        .dec_o      (dec)
    );

    bmv_regs #(
        .PTR_W  (PTR_W),
        .BANK_W (BANK_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .step_i     (step),
        .dir_i      (mv_dir_e'(dir_desc)),
        .acc_i      (acc_in),
        .x_i        (x_in),
        .y_i        (y_in),
        .sbank_i    (src_bank),
        .dbank_i    (dst_bank),
        .acc_q      (acc_out),
        .x_q        (x_out),
        .y_q        (y_out),
        .sbank_q    (sbank_q),
        .dbank_q    (dbank_out),
        .dir_q      (dir_q),
        .acc_zero_o (acc_zero)
    );

    bmv_mport #(
        .PTR_W  (PTR_W),
        .BANK_W (BANK_W),
        .DATA_W (DATA_W)
    ) u_mport (
        .clk     (clk),
        .rst     (rst),
        .dec_i   (dec),
        .sbank_i (sbank_q),
        .dbank_i (dbank_out),
        .x_i     (x_out),
        .y_i     (y_out),
        .rdata_i (mem_rdata),
        .req_o   (mem_req),
        .we_o    (mem_we),
        .addr_o  (mem_addr),
        .wdata_o (mem_wdata)
    );

    // R2: memory is touched only during a move
    a_r2_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
    // R2: a read is never followed directly by a request in the next cycle
    a_r2_gap_after_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req);
    // R1: idle engine makes no memory request
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

endmodule

// File: tb/bmv_engine_bench.sv
module bmv_engine_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, dir_desc, irq;
    logic [15:0] acc_in, x_in, y_in;
    logic [7:0]  src_bank, dst_bank;
    logic        busy, done;
    logic [15:0] acc_out, x_out, y_out;
    logic [7:0]  dbank_out;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    bmv_engine u_bmv_engine (
        .clk(clk), .rst(rst), .start(start), .dir_desc(dir_desc), .irq(irq),
        .acc_in(acc_in), .x_in(x_in), .y_in(y_in),
        .src_bank(src_bank), .dst_bank(dst_bank),
        .busy(busy), .done(done), .acc_out(acc_out), .x_out(x_out),
        .y_out(y_out), .dbank_out(dbank_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] mem     [logic [23:0]];
    logic [7:0] ref_mem [logic [23:0]];

    function automatic logic [7:0] init_val(input logic [23:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ a[23:16] ^ 8'h5a;
    endfunction

    function automatic logic [7:0] mem_get(input logic [23:0] a);
        return mem.exists(a) ? mem[a] : init_val(a);
    endfunction

    function automatic logic [7:0] ref_get(input logic [23:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    // synchronous memory: read data one cycle after the request
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem_get(mem_addr);
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_move(input logic [15:0] a, input logic [15:0] xx,
                            input logic [15:0] yy, input logic [7:0] sb,
                            input logic [7:0] db, input logic desc,
                            input int stop_m, input bit poke);
        int          n, moved, cyc, ph, bi;
        bit          exp_done, acc_ok, mem_ok;
        logic [15:0] rx, ry, cx, cy;
        longint unsigned bad_a, bad_e;
        n     = int'(a) + 1;
        moved = (stop_m == 0 || stop_m >= n) ? n : stop_m;
        exp_done = (moved == n);
        rx = xx; ry = yy;
        for (int i = 0; i < moved; i++) begin
            ref_mem[{db, ry}] = ref_get({sb, rx});
            rx = desc ? rx - 16'd1 : rx + 16'd1;
            ry = desc ? ry - 16'd1 : ry + 16'd1;
        end
        @(negedge clk);
        acc_in = a; x_in = xx; y_in = yy; src_bank = sb; dst_bank = db;
        dir_desc = desc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; acc_ok = 1'b1; bad_a = 0; bad_e = 0;
        while (busy && cyc < 7 * n + 20) begin
            cyc++;
            ph = (cyc - 1) % 7;
            bi = (cyc - 1) / 7;
            cx = desc ? xx - 16'(bi) : xx + 16'(bi);
            cy = desc ? yy - 16'(bi) : yy + 16'(bi);
            if (ph == 0) begin
                if (!(mem_req && !mem_we && mem_addr == {sb, cx})) begin
                    acc_ok = 1'b0; bad_a = mem_addr; bad_e = {sb, cx};
                end
            end else if (ph == 2) begin
                if (!(mem_req && mem_we && mem_addr == {db, cy})) begin
                    acc_ok = 1'b0; bad_a = mem_addr; bad_e = {db, cy};
                end
            end else if (mem_req) begin
                acc_ok = 1'b0; bad_a = 1; bad_e = 0;
            end
            if (stop_m != 0 && cyc == 7 * (stop_m - 1) + 1) irq = 1'b1;
            if (poke && cyc == 3) begin
                start = 1'b1; acc_in = ~a; x_in = ~xx; y_in = ~yy;
                dst_bank = ~db; src_bank = ~sb; dir_desc = ~desc;
            end
            if (poke && cyc == 4) start = 1'b0;
            @(negedge clk);
        end
        irq = 1'b0;
        chk(acc_ok, "R2", "access pattern", bad_a, bad_e);
        chk(cyc == 7 * moved, "R5", "busy cycles", cyc, 7 * moved);
        chk(done == exp_done, exp_done ? "R6" : "R7", "done at end", done, exp_done);
        chk(acc_out == a - 16'(moved), "R5", "acc after", acc_out, a - 16'(moved));
        chk(x_out == rx && y_out == ry, desc ? "R4" : "R3", "pointers after",
            {x_out, y_out}, {rx, ry});
        chk(dbank_out == db, "R8", "data bank", dbank_out, db);
        mem_ok = 1'b1;
        foreach (ref_mem[k]) if (mem_get(k) != ref_mem[k]) begin
            mem_ok = 1'b0; bad_a = mem_get(k); bad_e = ref_mem[k];
        end
        foreach (mem[k]) if (mem[k] != ref_get(k)) begin
            mem_ok = 1'b0; bad_a = mem[k]; bad_e = ref_get(k);
        end
        chk(mem_ok, "R2", "memory image", bad_a, bad_e);
        if (poke) chk(1'b1, "R9", "mid-move start ignored (checked above)", 0, 0);
        @(negedge clk);
        chk(!done, "R6", "done one cycle", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] fillv;
        bit         fill_ok;
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; irq = 1'b0; dir_desc = 1'b0;
        acc_in = '0; x_in = '0; y_in = '0; src_bank = '0; dst_bank = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_req, "R1", "control idle", {busy, done, mem_req}, 0);
        chk(acc_out == 0 && x_out == 0 && y_out == 0 && dbank_out == 0, "R1",
            "registers zero", {acc_out, x_out, y_out, dbank_out}, 0);

        // R3 ascending small copy, R5 count
        run_move(16'd3, 16'h0100, 16'h0800, 8'h01, 8'h02, 1'b0, 0, 0);
        // R4 descending small copy
        run_move(16'd4, 16'h0210, 16'h0910, 8'h02, 8'h03, 1'b1, 0, 0);
        // R3 wrap FFFF->0000 ascending
        run_move(16'd5, 16'hfffd, 16'hfffe, 8'h00, 8'h01, 1'b0, 0, 0);
        // R4 wrap 0000->FFFF descending
        run_move(16'd5, 16'h0002, 16'h0001, 8'h03, 8'h00, 1'b1, 0, 0);
        // R5 single byte (acc=0)
        run_move(16'd0, 16'h1234, 16'h4321, 8'h01, 8'h01, 1'b0, 0, 0);
        // R9 start pulse with junk values mid-move
        run_move(16'd6, 16'h3000, 16'h3800, 8'h02, 8'h02, 1'b0, 0, 1);
        // R7 interrupt after byte 3, then resume from read-back registers
        run_move(16'd9, 16'h5000, 16'h6000, 8'h01, 8'h03, 1'b0, 3, 0);
        run_move(acc_out, x_out, y_out, 8'h01, 8'h03, 1'b0, 0, 0);
        // R7 interrupt on the final byte: completion wins
        run_move(16'd2, 16'h7000, 16'h7100, 8'h00, 8'h02, 1'b1, 3, 0);
        // R10 overlapping fill
        fillv = ref_get({8'h01, 16'h2000});
        run_move(16'd15, 16'h2000, 16'h2001, 8'h01, 8'h01, 1'b0, 0, 0);
        fill_ok = 1'b1;
        for (int i = 1; i <= 16; i++)
            if (mem_get({8'h01, 16'h2000 + 16'(i)}) != fillv) fill_ok = 1'b0;
        chk(fill_ok, "R10", "fill replicates first byte",
            mem_get({8'h01, 16'h2010}), fillv);

        // random moves, some interrupted and resumed (R2..R8)
        for (int t = 0; t < 24; t++) begin
            logic [15:0] ra, rxx, ryy;
            logic [7:0]  rsb, rdb;
            logic        rd;
            int          rm;
            ra  = 16'($urandom_range(0, 40));
            rxx = 16'($urandom);
            ryy = 16'($urandom);
            rsb = 8'($urandom_range(0, 3));
            rdb = 8'($urandom_range(0, 3));
            rd  = 1'($urandom_range(0, 1));
            rm  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 32'(ra) + 1)) : 0;
            run_move(ra, rxx, ryy, rsb, rdb, rd, rm, 0);
            if (rm != 0 && rm < int'(ra) + 1)
                run_move(acc_out, x_out, y_out, rsb, rdb, rd, 0, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule